// File: doc/BRIEF.md
# SPI Master with Register Window

This block is an SPI master that a processor reaches through a 32-bit register bus with a 1 KiB address window. Software sets up two free-form control words, places a word in the data register, and the block sends its low byte on the serial lines. At the same time it collects the byte that comes back. The received byte then replaces the data register and a receive flag in the status word is raised.

A read of the data register is also an exchange. The block sends whatever the data register currently holds and holds the bus until the answer has arrived. It then returns the received word and clears the receive flag in the same access.

Several registers exist only so that older driver code still finds them. A polynomial word, two checksum words and two audio-mode words all answer with fixed values. The checksum words also flag a write attempt on a bus error line.

The serial side runs in clock-polarity-0 / clock-phase-0 form. Frames are most significant bit first, and the serial clock is a fixed division of the system clock.

The bus handshake works as follows. The host raises `bus_req` with `bus_we`, `bus_addr` and `bus_wdata` held steady. The access completes on the rising clock edge where `bus_ready` is high. `bus_rdata` and `bus_err` are valid in that same cycle.

Top module: `spim_csr_top`

## Requirements
- R1: After reset the registers read as follows: ctrl0 (0x00) = 0, ctrl1 (0x04) = 0, status (0x08) = 0x0000000A, data (0x0C) = 0x0000000C, polynomial (0x10) = 7, receive checksum (0x14) = 0, send checksum (0x18) = 0, audio config (0x1C) = 0, audio prescaler (0x20) = 2. The chip select `spi_cs_n` is high and `spi_sclk` is low.
- R2: Some accesses fall outside the nine decoded word offsets: any other offset in the window, or a byte address whose two low bits are not zero. Such an access completes at once, reads zero and changes nothing. In particular, a misaligned access near the data offset starts no exchange.
- R3: ctrl0 and ctrl1 store all 32 written bits and read them back unchanged. No value in ctrl1 alters the exchange behaviour.
- R4: A write to the data offset stores the word and starts an exchange. When the block is idle, the write completes in its request cycle and `spi_cs_n` falls two clock edges after the accepting edge. When an exchange is already running, a new data write is held off (`bus_ready` low) until that exchange ends.
- R5: A frame carries `XFER_BITS` (8) bits, most significant first. `spi_mosi` is stable at each rising `spi_sclk` edge, where the master samples `spi_miso`. `spi_sclk` idles low, has a period of `SCLK_DIV` (4) system clocks, and toggles only while `spi_cs_n` is low.
- R6: When an exchange ends, the data register holds the received byte, zero-extended to 32 bits, and status bit 0 (receive-not-empty) is set.
- R7: A read of the data offset sends the current data-register contents as a frame. `bus_ready` stays low until the frame has finished. The read then returns the received word and clears receive-not-empty.
- R8: The status register ignores bus writes.
- R9: Writes to the polynomial (0x10), audio config (0x1C) and audio prescaler (0x20) registers are discarded. These registers keep reading 7, 0 and 2.
- R10: The receive checksum (0x14) and send checksum (0x18) registers read zero. A write to either completes with `bus_err` high for that cycle. `bus_err` is low for every other access.
- R11: The status bits are laid out as follows. Bit 7 (busy) is high and bit 1 (transmit-empty) is low from the accepting edge of an exchange until it ends, covering the whole time `spi_cs_n` is low. Bit 3 always reads one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, held until ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (10) | Byte address within the window |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid while ready is high |
| bus_ready | output | 1 | Access completes on this cycle's edge |
| bus_err | output | 1 | Write attempt to a read-only checksum register |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, low for a frame |

## Verification
The bench builds the block with its defaults: a 10-bit byte address, 32-bit words, 8-bit frames and a divide-by-4 serial clock. Each exchange therefore takes about 34 system clocks. This keeps every register offset, the unaligned addresses and some holes beyond the last register within a short run. It also leaves room for many back-to-back frames. A behavioural slave on the serial lines supplies known answer bytes and records the bits and clock period it sees. This lets the bench confirm the bit order, the divided clock rate and that a data read sends the previous answer.

// File: rtl/spim_pkg.sv
// Package: shared constants for the SPI master register window.
// Assumes word-aligned registers; the word index is the byte address >> 2.
package spim_pkg;

    // Word indices of the decoded registers (byte offset / 4).
    localparam int IDX_CTRL0   = 0;
    localparam int IDX_CTRL1   = 1;
    localparam int IDX_STATUS  = 2;
    localparam int IDX_DATA    = 3;
    localparam int IDX_POLY    = 4;
    localparam int IDX_RXSUM   = 5;
    localparam int IDX_TXSUM   = 6;
    localparam int IDX_AUDCFG  = 7;
    localparam int IDX_AUDPRE  = 8;
    localparam int IDX_LAST    = IDX_AUDPRE;

    // Fixed / reset register contents.
    localparam logic [31:0] RST_DATA   = 32'h0000_000C;
    localparam logic [31:0] VAL_POLY   = 32'h0000_0007;
    localparam logic [31:0] VAL_AUDCFG = 32'h0000_0000;
    localparam logic [31:0] VAL_AUDPRE = 32'h0000_0002;

    // Status bit positions.
    localparam int STAT_RXNE = 0;
    localparam int STAT_TXE  = 1;
    localparam int STAT_RSV1 = 3;
    localparam int STAT_BUSY = 7;

    // Progress of a data-register read that owns an exchange.
    typedef enum logic [1:0] {
        RD_IDLE,
        RD_WAIT,
        RD_DONE
    } rd_state_e;

endpackage

// File: rtl/spim_shift.sv
// Module: spim_shift
// Serial shift engine: sends BITS bits MSB-first in clock-polarity-0 /
// clock-phase-0 form and samples the input on each rising serial clock.
// Assumes CLK_DIV is even and at least 2; start is ignored while running.
module spim_shift #(
    parameter int BITS    = 8,
    parameter int CLK_DIV = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [BITS-1:0] tx_i,
    output logic            done_o,
    output logic [BITS-1:0] rx_o,
    output logic            sclk_o,
    output logic            mosi_o,
    input  logic            miso_i,
    output logic            cs_n_o
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BIT_W = (BITS > 1) ? $clog2(BITS) : 1;

    logic             running_q;
    logic             sclk_q;
    logic             cs_n_q;
    logic             done_q;
    logic [DIV_W-1:0] div_q;
    logic [BIT_W-1:0] bit_q;
    logic [BITS-1:0]  tx_sr_q;
    logic [BITS-1:0]  rx_sr_q;

    // Frame sequencing: divide the clock, toggle sclk, shift both registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            sclk_q    <= 1'b0;
            cs_n_q    <= 1'b1;
            done_q    <= 1'b0;
            div_q     <= '0;
            bit_q     <= '0;
            tx_sr_q   <= '0;
            rx_sr_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (!running_q) begin
                if (start_i) begin
                    running_q <= 1'b1;
                    cs_n_q    <= 1'b0;
                    tx_sr_q   <= tx_i;
                    div_q     <= '0;
                    bit_q     <= '0;
                end
            end else if (div_q == DIV_W'(HALF - 1)) begin
                div_q <= '0;
                if (!sclk_q) begin
                    sclk_q  <= 1'b1;
                    rx_sr_q <= {rx_sr_q[BITS-2:0], miso_i};
                end else begin
                    sclk_q <= 1'b0;
                    if (bit_q == BIT_W'(BITS - 1)) begin
                        running_q <= 1'b0;
                        cs_n_q    <= 1'b1;
                        done_q    <= 1'b1;
                    end else begin
                        bit_q   <= bit_q + BIT_W'(1);
                        tx_sr_q <= {tx_sr_q[BITS-2:0], 1'b0};
                    end
                end
            end else begin
                div_q <= div_q + DIV_W'(1);
            end
        end
    end

    assign done_o = done_q;
    assign rx_o   = rx_sr_q;
    assign sclk_o = sclk_q;
    assign cs_n_o = cs_n_q;
    assign mosi_o = tx_sr_q[BITS-1];

endmodule

// File: rtl/spim_bus_regs.sv
// Module: spim_bus_regs
// Register window: decodes the bus, holds control/data/status state,
// and sequences exchanges for data writes and stalling data reads.
// Assumes one host that holds its request steady until bus_ready.
module spim_bus_regs #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int BITS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ready_o,
    output logic              err_o,
    output logic              start_o,
    output logic [BITS-1:0]   tx_o,
    input  logic              done_i,
    input  logic [BITS-1:0]   rx_i,
    output logic              busy_o
);
    import spim_pkg::*;

    localparam int IDX_W = ADDR_W - 2;

    logic [DATA_W-1:0] ctrl0_q;
    logic [DATA_W-1:0] ctrl1_q;
    logic [DATA_W-1:0] data_q;
    logic              rxne_q;
    logic              busy_q;
    logic              start_q;
    rd_state_e         rd_q;

    logic              aligned;
    logic [IDX_W-1:0]  idx;
    logic              sel_data;
    logic              wr_go;
    logic              rd_go;
    logic              rd_fin;
    logic [DATA_W-1:0] status_w;

    // Address decode and handshake decisions for the current request.
    always_comb begin
        aligned  = (addr_i[1:0] == 2'b00);
        idx      = addr_i[ADDR_W-1:2];
        sel_data = req_i && aligned && (idx == IDX_W'(IDX_DATA));
        wr_go    = sel_data && we_i && !busy_q && (rd_q == RD_IDLE);
        rd_go    = sel_data && !we_i && !busy_q && (rd_q == RD_IDLE);
        rd_fin   = sel_data && !we_i && (rd_q == RD_DONE);
        ready_o  = req_i && (!sel_data || wr_go || rd_fin);
        err_o    = req_i && we_i && aligned &&
                   ((idx == IDX_W'(IDX_RXSUM)) || (idx == IDX_W'(IDX_TXSUM)));
    end

    // Status word assembly.
    always_comb begin
        status_w            = '0;
        status_w[STAT_RXNE] = rxne_q;
        status_w[STAT_TXE]  = !busy_q;
        status_w[STAT_RSV1] = 1'b1;
        status_w[STAT_BUSY] = busy_q;
    end

    // Read multiplexer; holes and misaligned addresses read zero.
    always_comb begin
        rdata_o = '0;
        if (aligned) begin
            case (idx)
                IDX_W'(IDX_CTRL0):  rdata_o = ctrl0_q;
                IDX_W'(IDX_CTRL1):  rdata_o = ctrl1_q;
                IDX_W'(IDX_STATUS): rdata_o = status_w;
                IDX_W'(IDX_DATA):   rdata_o = data_q;
                IDX_W'(IDX_POLY):   rdata_o = DATA_W'(VAL_POLY);
                IDX_W'(IDX_AUDCFG): rdata_o = DATA_W'(VAL_AUDCFG);
                IDX_W'(IDX_AUDPRE): rdata_o = DATA_W'(VAL_AUDPRE);
                default:            rdata_o = '0;
            endcase
        end
    end

    // Control registers: plain storage, written on any decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl0_q <= '0;
            ctrl1_q <= '0;
        end else if (req_i && we_i && aligned) begin
            if (idx == IDX_W'(IDX_CTRL0)) ctrl0_q <= wdata_i;
            if (idx == IDX_W'(IDX_CTRL1)) ctrl1_q <= wdata_i;
        end
    end

    // Exchange sequencing: data register, receive flag, busy and read state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= DATA_W'(RST_DATA);
            rxne_q  <= 1'b0;
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            rd_q    <= RD_IDLE;
        end else begin
            start_q <= 1'b0;
            if (wr_go) begin
                data_q  <= wdata_i;
                start_q <= 1'b1;
                busy_q  <= 1'b1;
            end
            if (rd_go) begin
                start_q <= 1'b1;
                busy_q  <= 1'b1;
                rd_q    <= RD_WAIT;
            end
            if (done_i) begin
                busy_q <= 1'b0;
                data_q <= DATA_W'(rx_i);
                rxne_q <= 1'b1;
                if (rd_q == RD_WAIT) rd_q <= RD_DONE;
            end
            if (rd_fin) begin
                rxne_q <= 1'b0;
                rd_q   <= RD_IDLE;
            end
        end
    end

    assign start_o = start_q;
    assign tx_o    = data_q[BITS-1:0];
    assign busy_o  = busy_q;

endmodule

// File: rtl/spim_csr_top.sv
// Module: spim_csr_top
// SPI master behind a register window: joins the bus register block
// to the serial shift engine. Assumes a single bus host.
module spim_csr_top #(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 32,
    parameter int XFER_BITS = 8,
    parameter int SCLK_DIV  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              bus_err,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    logic                 xfer_start;
    logic                 xfer_done;
    logic                 xfer_busy;
    logic [XFER_BITS-1:0] xfer_tx;
    logic [XFER_BITS-1:0] xfer_rx;

    spim_bus_regs #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .BITS  (XFER_BITS)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (bus_req),
        .we_i   (bus_we),
        .addr_i (bus_addr),
        .wdata_i(bus_wdata),
        .rdata_o(bus_rdata),
        .ready_o(bus_ready),
        .err_o  (bus_err),
        .start_o(xfer_start),
        .tx_o   (xfer_tx),
        .done_i (xfer_done),
        .rx_i   (xfer_rx),
        .busy_o (xfer_busy)
    );

    spim_shift #(
        .BITS   (XFER_BITS),
        .CLK_DIV(SCLK_DIV)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(xfer_start),
        .tx_i   (xfer_tx),
        .done_o (xfer_done),
        .rx_o   (xfer_rx),
        .sclk_o (spi_sclk),
        .mosi_o (spi_mosi),
        .miso_i (spi_miso),
        .cs_n_o (spi_cs_n)
    );

endmodule

// File: rtl/spim_csr_sva.sv
// Module: spim_csr_sva
// Property checker for spim_csr_top, attached by bind below.
// Assumes the bus host holds its request steady until bus_ready.
module spim_csr_sva #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_ready,
    input logic              bus_err,
    input logic              spi_sclk,
    input logic              spi_cs_n,
    input logic              xfer_busy
);
    import spim_pkg::*;

    localparam int IDX_W = ADDR_W - 2;

    logic is_data;
    logic is_hole;

    // Independent decode of the data offset and of undecoded addresses.
    always_comb begin
        is_data = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:2] == IDX_W'(IDX_DATA));
        is_hole = (bus_addr[1:0] != 2'b00) || (bus_addr[ADDR_W-1:2] > IDX_W'(IDX_LAST));
    end

    // R2: holes read zero
    a_r2_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_ready && is_hole) |-> (bus_rdata == '0));

    // R4: an accepted data write drops chip select two edges later
    a_r4_write_opens_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && is_data && bus_ready) |=> ##1 !spi_cs_n);

    // R5: serial clock only inside a frame, each level held two cycles
    a_r5_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !spi_cs_n);
    a_r5_sclk_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sclk) |=> spi_sclk);
    a_r5_sclk_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(spi_sclk) && !spi_cs_n) |=> !spi_sclk);

    // R7: a data read cannot complete while an exchange is running
    a_r7_read_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && is_data && xfer_busy) |-> !bus_ready);

    // R10: the error line only marks completing writes
    a_r10_err_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_ready && bus_we));

    // R11: busy covers the whole frame
    a_r11_busy_spans_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> xfer_busy);

endmodule

bind spim_csr_top spim_csr_sva #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .bus_ready(bus_ready),
    .bus_err  (bus_err),
    .spi_sclk (spi_sclk),
    .spi_cs_n (spi_cs_n),
    .xfer_busy(xfer_busy)
);

// File: tb/spim_csr_top_tb_top.sv
// Directed bench for spim_csr_top with a behavioural serial slave.
module spim_csr_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        bus_err;
    logic        spi_sclk;
    logic        spi_mosi;
    logic        spi_miso = 1'b0;
    logic        spi_cs_n;

    int n_checks = 0;
    int n_fails  = 0;

    // Slave model state.
    logic [7:0] slave_byte = 8'h00;
    logic [7:0] slave_sr   = 8'h00;
    logic [7:0] mosi_cap   = 8'h00;
    int         rise_cnt   = 0;
    time        last_rise  = 0;
    time        sclk_per   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spim_csr_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .bus_ready(bus_ready),
        .bus_err  (bus_err),
        .spi_sclk (spi_sclk),
        .spi_mosi (spi_mosi),
        .spi_miso (spi_miso),
        .spi_cs_n (spi_cs_n)
    );

    // Slave: load the answer when a frame opens.
    initial forever begin
        @(negedge spi_cs_n);
        slave_sr = slave_byte;
        spi_miso = slave_sr[7];
        mosi_cap = 8'h00;
        rise_cnt = 0;
    end

    // Slave: present the next answer bit after each falling serial clock.
    initial forever begin
        @(negedge spi_sclk);
        slave_sr = {slave_sr[6:0], 1'b0};
        spi_miso = slave_sr[7];
    end

    // Slave: capture the master's bit and the serial clock period.
    initial forever begin
        @(posedge spi_sclk);
        mosi_cap = {mosi_cap[6:0], spi_mosi};
        rise_cnt = rise_cnt + 1;
        if (rise_cnt > 1) sclk_per = $time - last_rise;
        last_rise = $time;
    end

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
        end
    endtask

    // One bus access; returns read data, error flag and wait cycles.
    task automatic bus_xfer(input logic we, input logic [9:0] a, input logic [31:0] wd,
                            output logic [31:0] rd, output logic er, output int waits);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
        waits = 0;
        #1;
        while (!bus_ready) begin
            @(negedge clk); #1;
            waits++;
        end
        rd = bus_rdata;
        er = bus_err;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string rq, input logic [9:0] a, input logic [31:0] exp);
        logic [31:0] rd; logic er; int w;
        bus_xfer(1'b0, a, 32'h0, rd, er, w);
        check(rq, rd, exp);
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] wd);
        logic [31:0] rd; logic er; int w;
        bus_xfer(1'b1, a, wd, rd, er, w);
    endtask

    task automatic wait_idle();
        logic [31:0] rd; logic er; int w;
        rd = 32'h80;
        while (rd[7]) bus_xfer(1'b0, 10'h008, 32'h0, rd, er, w);
    endtask

    task automatic t_reset();
        logic [31:0] rd; logic er; int w;
        check("R1 cs_n idle", 32'(spi_cs_n), 32'h1);
        check("R1 sclk idle", 32'(spi_sclk), 32'h0);
        rd_chk("R1 ctrl0", 10'h000, 32'h0);
        rd_chk("R1 ctrl1", 10'h004, 32'h0);
        rd_chk("R1 status", 10'h008, 32'h0A);
        rd_chk("R1 poly", 10'h010, 32'h7);
        rd_chk("R1 rxsum", 10'h014, 32'h0);
        rd_chk("R1 txsum", 10'h018, 32'h0);
        rd_chk("R1 audcfg", 10'h01C, 32'h0);
        rd_chk("R1 audpre", 10'h020, 32'h2);
        slave_byte = 8'h5E;
        bus_xfer(1'b0, 10'h00C, 32'h0, rd, er, w);
        check("R1 data reset value sent", 32'(mosi_cap), 32'h0C);
        check("R7 read returns answer", rd, 32'h5E);
    endtask

    task automatic t_ctrl();
        wr(10'h000, 32'hDEAD_BEEF);
        wr(10'h004, 32'hFFFF_FFFF);
        rd_chk("R3 ctrl0 readback", 10'h000, 32'hDEAD_BEEF);
        rd_chk("R3 ctrl1 readback", 10'h004, 32'hFFFF_FFFF);
    endtask

    task automatic t_holes();
        wr(10'h024, 32'h1234_5678);
        rd_chk("R2 hole 0x24", 10'h024, 32'h0);
        rd_chk("R2 hole 0x3FC", 10'h3FC, 32'h0);
        rd_chk("R2 misaligned 0x01", 10'h001, 32'h0);
        rd_chk("R2 misaligned 0x0D read", 10'h00D, 32'h0);
        wr(10'h00E, 32'h0000_00FF);
        repeat (4) @(negedge clk);
        check("R2 misaligned write no frame", 32'(spi_cs_n), 32'h1);
        rd_chk("R2 status untouched", 10'h008, 32'h0A);
    endtask

    task automatic t_write_xfer();
        slave_byte = 8'h3C;
        wr(10'h00C, 32'h1234_56A5);
        rd_chk("R11 status busy", 10'h008, 32'h88);
        wait_idle();
        check("R5 mosi bits msb first", 32'(mosi_cap), 32'hA5);
        check("R5 bit count", 32'(rise_cnt), 32'd8);
        check("R5 sclk period", 32'(sclk_per), 32'(4 * CLK_PERIOD));
        rd_chk("R6 status rxne set", 10'h008, 32'h0B);
    endtask

    task automatic t_read_xfer();
        logic [31:0] rd; logic er; int w;
        slave_byte = 8'h81;
        bus_xfer(1'b0, 10'h00C, 32'h0, rd, er, w);
        check("R6 previous answer sent", 32'(mosi_cap), 32'h3C);
        check("R7 read answer", rd, 32'h81);
        check("R7 read stalled", 32'(w >= 32), 32'h1);
        rd_chk("R7 rxne cleared", 10'h008, 32'h0A);
    endtask

    task automatic t_status_ro();
        wr(10'h008, 32'hFFFF_FFFF);
        rd_chk("R8 status ignores write", 10'h008, 32'h0A);
    endtask

    task automatic t_stubs();
        wr(10'h010, 32'hFFFF_FFFF);
        wr(10'h01C, 32'hFFFF_FFFF);
        wr(10'h020, 32'hFFFF_FFFF);
        rd_chk("R9 poly kept", 10'h010, 32'h7);
        rd_chk("R9 audcfg kept", 10'h01C, 32'h0);
        rd_chk("R9 audpre kept", 10'h020, 32'h2);
    endtask

    task automatic t_sum_ro();
        logic [31:0] rd; logic er; int w;
        bus_xfer(1'b1, 10'h014, 32'hFFFF_FFFF, rd, er, w);
        check("R10 rxsum write err", 32'(er), 32'h1);
        bus_xfer(1'b1, 10'h018, 32'hFFFF_FFFF, rd, er, w);
        check("R10 txsum write err", 32'(er), 32'h1);
        bus_xfer(1'b0, 10'h014, 32'h0, rd, er, w);
        check("R10 rxsum read no err", 32'(er), 32'h0);
        check("R10 rxsum reads zero", rd, 32'h0);
        bus_xfer(1'b1, 10'h000, 32'h0, rd, er, w);
        check("R10 ctrl write no err", 32'(er), 32'h0);
    endtask

    task automatic t_back2back();
        logic [31:0] rd; logic er; int w;
        slave_byte = 8'hC3;
        wr(10'h00C, 32'h11);
        bus_xfer(1'b1, 10'h00C, 32'h22, rd, er, w);
        check("R4 second write held off", 32'(w >= 20), 32'h1);
        wait_idle();
        check("R4 second frame data", 32'(mosi_cap), 32'h22);
        rd_chk("R11 idle status", 10'h008, 32'h0B);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog R1..all actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    // Main sequence.
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_holes();
        t_write_xfer();
        t_read_xfer();
        t_status_ro();
        t_stubs();
        t_sum_ro();
        t_back2back();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule